// File: doc/BRIEF.md
# Host Register Port for a Two-Wire Bus Master

This block is the register file that a processor sees when it drives a two-wire (I2C) bus master. It sits on an 8-bit synchronous processor bus. That bus has an active-low select, a 3-bit register address and a direction line (high = read, low = write). The block holds the configuration that the serial engine needs: the slave address with its direction bit, the transfer length, the speed mode and the interrupt enables. It also holds a one-byte buffer that is shared by transmit and receive.

On the engine side, the block issues one-cycle start and stop strobes. It accepts simple strobes from the engine: "transmit byte taken" and "receive byte loaded". It accepts five level inputs that report the engine's state. Two flags, transmit-empty and receive-full, give the handshake with the processor. The processor can poll these flags in the status byte, or it can let them drive an active-low interrupt line. The interrupt is released by an acknowledge write.

Top module: `hostif_top`

## Requirements
- R1: After a synchronous reset with `rst_n` low, every register reads 0. The status byte reads 0x02, because transmit-empty resets to 1 and every other flag resets to 0. `irq_n` is 1 and `eng_go` is 0.
- R2: A write takes effect on the third rising clock edge at which `cs_n` is sampled low. It takes effect only once per select, even if the select is held longer. Writes to addresses 010, 011 and 111 change nothing.
- R3: While `cs_n` is low and `wr_n` is high, `rdata` returns a value chosen by `addr`: 000 the data buffer, 001 the slave address register, 100 the status byte, 101 the byte count. Addresses 110, 010, 011 and 111 read 0. At all other times `rdata` is 0.
- R4: The register at 001 holds the 7-bit slave address in bits 7..1, output on `eng_slave_addr`. Its bit 0 is output as the transfer direction on `eng_rw`.
- R5: A write to 100 works bit by bit. Bit 7 produces a one-cycle `eng_go` pulse. Bit 6 produces a one-cycle `eng_abort` pulse. Bit 3 sets `eng_fast` (0 = 100 kbit/s, 1 = 400 kbit/s). Bit 1 enables the transmit interrupt and bit 0 enables the receive interrupt. Go may be written in the same byte as the other bits.
- R6: The status byte read at 100 has this layout: bit 7 busy, bit 6 error, bit 5 abort acknowledged, bit 4 lost arbitration, bit 3 done, bit 2 always 0, bit 1 transmit-empty, bit 0 receive-full.
- R7: A processor write to 000 clears transmit-empty. `eng_tx_take` sets it. If both happen in the same cycle, the clear wins.
- R8: `eng_rx_load` loads `eng_rx_byte` into the data buffer and sets receive-full. A processor read of 000 clears receive-full at its commit edge. If the load and the read commit fall in the same cycle, the set wins.
- R9: An interrupt becomes pending in two cases: transmit-empty with bit 1 enabled becomes true, or receive-full with bit 0 enabled becomes true. `irq_n` goes low one clock after the flag or enable that caused it is updated.
- R10: A write to 110 with bit 0 set releases a pending interrupt, and `irq_n` returns to 1. A write to 110 with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Register select, active low |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Interrupt request, active low |
| eng_go | output | 1 | One-cycle start strobe to the engine |
| eng_abort | output | 1 | One-cycle stop strobe to the engine |
| eng_fast | output | 1 | Speed mode, 1 = 400 kbit/s |
| eng_slave_addr | output | 7 | Target slave address |
| eng_rw | output | 1 | Transfer direction bit |
| eng_byte_cnt | output | 8 | Number of bytes in the transfer |
| eng_tx_byte | output | 8 | Byte to transmit (the data buffer) |
| eng_tx_take | input | 1 | Engine has taken the transmit byte |
| eng_rx_load | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_busy | input | 1 | Bus busy |
| eng_error | input | 1 | Transfer error |
| eng_abort_ack | input | 1 | Abort completed |
| eng_lost_arb | input | 1 | Arbitration lost |
| eng_done | input | 1 | Transfer done |

## Verification
Both buffer flags can be set by the engine and cleared by the processor in the same clock. A processor data write can commit on the same edge as `eng_tx_take`, and a processor data read can commit on the same edge as `eng_rx_load`. The bench raises the engine strobe exactly over the third select edge of such an access. It then judges the outcome from the status byte: transmit-empty must stay 0, and receive-full must stay 1. A follow-up read of the buffer must return the newly loaded byte.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_DATA  = 3'b000;
  localparam logic [AW-1:0] A_SADDR = 3'b001;
  localparam logic [AW-1:0] A_CMD   = 3'b100;
  localparam logic [AW-1:0] A_BCNT  = 3'b101;
  localparam logic [AW-1:0] A_IACK  = 3'b110;

  localparam int CMD_GO    = 7;
  localparam int CMD_ABORT = 6;
  localparam int CMD_FAST  = 3;
  localparam int CMD_TXIE  = 1;
  localparam int CMD_RXIE  = 0;

  typedef struct packed {
    logic busy;
    logic err;
    logic abort_ack;
    logic lost_arb;
    logic done;
  } eng_state_t;

  function automatic logic [DW-1:0] pack_status(eng_state_t s, logic tx_empty, logic rx_full);
    return {s.busy, s.err, s.abort_ack, s.lost_arb, s.done, 1'b0, tx_empty, rx_full};
  endfunction

  function automatic logic [DW-1:0] read_sel(logic [AW-1:0] a, logic [DW-1:0] data,
                                             logic [DW-1:0] saddr, logic [DW-1:0] status,
                                             logic [DW-1:0] bcnt);
    case (a)
      A_DATA:  return data;
      A_SADDR: return saddr;
      A_CMD:   return status;
      A_BCNT:  return bcnt;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hostif_bus.sv
module hostif_bus #(
  parameter int COMMIT_EDGE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_commit,
  output logic rd_commit
);
  localparam int CW = $clog2(COMMIT_EDGE + 1);
  logic [CW-1:0] cnt_q;
  logic          at_edge;

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) cnt_q <= '0;
    else if (cnt_q != CW'(COMMIT_EDGE)) cnt_q <= cnt_q + 1'b1;
  end

  assign at_edge   = !cs_n && (cnt_q == CW'(COMMIT_EDGE - 1));
  assign wr_commit = at_edge && !wr_n;
  assign rd_commit = at_edge && wr_n;
endmodule

// File: rtl/hostif_regs.sv
module hostif_regs
  import hostif_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_commit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] databuf,
  output logic [DW-1:0] saddr,
  output logic [DW-1:0] bcnt,
  output logic          fast,
  output logic [1:0]    irq_en,
  output logic          go_pulse,
  output logic          abort_pulse,
  output logic          data_wr,
  output logic          iack
);
  logic cmd_wr;

  assign cmd_wr  = wr_commit && (addr == A_CMD);
  assign data_wr = wr_commit && (addr == A_DATA);
  assign iack    = wr_commit && (addr == A_IACK) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      databuf <= '0;
      saddr   <= '0;
      bcnt    <= '0;
      fast    <= 1'b0;
      irq_en  <= '0;
    end else begin
      if (rx_load) databuf <= rx_byte;
      if (wr_commit) begin
        case (addr)
          A_DATA:  databuf <= wdata;
          A_SADDR: saddr   <= wdata;
          A_BCNT:  bcnt    <= wdata;
          A_CMD: begin
            fast   <= wdata[CMD_FAST];
            irq_en <= {wdata[CMD_TXIE], wdata[CMD_RXIE]};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_pulse    <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      go_pulse    <= cmd_wr && wdata[CMD_GO];
      abort_pulse <= cmd_wr && wdata[CMD_ABORT];
    end
  end
endmodule

// File: rtl/hostif_irq.sv
module hostif_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_wr,
  input  logic            data_rd,
  input  logic            tx_take,
  input  logic            rx_load,
  input  logic            iack,
  input  logic [NSRC-1:0] src_en,
  output logic            tx_empty,
  output logic            rx_full,
  output logic            raise,
  output logic            irq_n
);
  logic [NSRC-1:0] flags, cond, prev_q, rise;
  logic            pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tx_empty <= 1'b1;
    else if (data_wr) tx_empty <= 1'b0;
    else if (tx_take) tx_empty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_full <= 1'b0;
    else if (rx_load) rx_full <= 1'b1;
    else if (data_rd) rx_full <= 1'b0;
  end

  assign flags = NSRC'({tx_empty, rx_full});

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign cond[g] = flags[g] & src_en[g];
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= cond[g];
    end
    assign rise[g] = cond[g] & ~prev_q[g];
  end

  assign raise = |rise;

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (raise) pend_q <= 1'b1;
    else if (iack)  pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/hostif_top.sv
module hostif_top
  import hostif_pkg::*;
#(
  parameter int COMMIT_EDGE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n,
  output logic          eng_go,
  output logic          eng_abort,
  output logic          eng_fast,
  output logic [6:0]    eng_slave_addr,
  output logic          eng_rw,
  output logic [DW-1:0] eng_byte_cnt,
  output logic [DW-1:0] eng_tx_byte,
  input  logic          eng_tx_take,
  input  logic          eng_rx_load,
  input  logic [DW-1:0] eng_rx_byte,
  input  logic          eng_busy,
  input  logic          eng_error,
  input  logic          eng_abort_ack,
  input  logic          eng_lost_arb,
  input  logic          eng_done
);
  logic          wr_commit, rd_commit, data_wr, data_rd, iack, raise;
  logic          tx_empty, rx_full;
  logic [1:0]    irq_en;
  logic [DW-1:0] databuf, saddr, bcnt, status;
  eng_state_t    est;

  hostif_bus #(.COMMIT_EDGE(COMMIT_EDGE)) bus_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .wr_commit(wr_commit), .rd_commit(rd_commit)
  );

  hostif_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .addr(addr), .wdata(wdata),
    .rx_load(eng_rx_load), .rx_byte(eng_rx_byte),
    .databuf(databuf), .saddr(saddr), .bcnt(bcnt), .fast(eng_fast), .irq_en(irq_en),
    .go_pulse(eng_go), .abort_pulse(eng_abort), .data_wr(data_wr), .iack(iack)
  );

  assign data_rd = rd_commit && (addr == A_DATA);

  hostif_irq #(.NSRC(2)) irq_i (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_rd(data_rd),
    .tx_take(eng_tx_take), .rx_load(eng_rx_load), .iack(iack), .src_en(irq_en),
    .tx_empty(tx_empty), .rx_full(rx_full), .raise(raise), .irq_n(irq_n)
  );

  assign est    = '{busy: eng_busy, err: eng_error, abort_ack: eng_abort_ack,
                    lost_arb: eng_lost_arb, done: eng_done};
  assign status = pack_status(est, tx_empty, rx_full);
  assign rdata  = (!cs_n && wr_n) ? read_sel(addr, databuf, saddr, status, bcnt) : '0;

  assign eng_slave_addr = saddr[7:1];
  assign eng_rw         = saddr[0];
  assign eng_byte_cnt   = bcnt;
  assign eng_tx_byte    = databuf;
endmodule

// File: rtl/hostif_chk.sv
module hostif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       irq_n,
  input logic       eng_go,
  input logic       wr_commit,
  input logic       rd_commit,
  input logic       data_wr,
  input logic       rx_load,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       raise,
  input logic       iack
);
  // R2
  commit_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || rd_commit) |-> !cs_n);
  // R2
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
  // R3
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rdata == 8'h00));
  // R5
  go_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  // R5
  go_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> $past(wr_commit));
  // R6
  status_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wr_n && addr == 3'b100) |-> !rdata[2]);
  // R7
  tx_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_empty);
  // R8
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rx_full);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> !irq_n);
  // R10
  iack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !raise) |=> irq_n);
endmodule

bind hostif_top hostif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .rdata(rdata),
  .irq_n(irq_n), .eng_go(eng_go), .wr_commit(wr_commit), .rd_commit(rd_commit),
  .data_wr(data_wr), .rx_load(eng_rx_load), .tx_empty(tx_empty), .rx_full(rx_full),
  .raise(raise), .iack(iack)
);

// File: tb/hostif_top_tb_top.sv
module hostif_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rx_byte = '0;
  logic       irq_n, eng_go, eng_abort, eng_fast, eng_rw;
  logic [6:0] eng_slave_addr;
  logic [7:0] eng_byte_cnt, eng_tx_byte;
  logic       tx_take = 1'b0, rx_load = 1'b0;
  logic       busy = 0, err = 0, aack = 0, lost = 0, done = 0;
  int         errors = 0, checks = 0, cycles = 0, go_seen = 0, abort_seen = 0;
  logic [7:0] q;

  always #5 clk = ~clk;

  hostif_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n), .eng_go(eng_go), .eng_abort(eng_abort),
    .eng_fast(eng_fast), .eng_slave_addr(eng_slave_addr), .eng_rw(eng_rw),
    .eng_byte_cnt(eng_byte_cnt), .eng_tx_byte(eng_tx_byte), .eng_tx_take(tx_take),
    .eng_rx_load(rx_load), .eng_rx_byte(rx_byte), .eng_busy(busy), .eng_error(err),
    .eng_abort_ack(aack), .eng_lost_arb(lost), .eng_done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (eng_go) go_seen <= go_seen + 1;
    if (eng_abort) abort_seen <= abort_seen + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // side: 0 none, 1 tx_take over the commit edge, 2 rx_load over the commit edge
  task automatic cpu_acc(input logic [2:0] a, input logic rd, input logic [7:0] d,
                         input int side, output logic [7:0] res);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wr_n = rd; wdata = d; res = '0;
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 1) res = rdata;
      if (i == 2 && side == 1) tx_take = 1'b1;
      if (i == 2 && side == 2) rx_load = 1'b1;
      if (i == 3) begin tx_take = 1'b0; rx_load = 1'b0; end
    end
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    cpu_acc(a, 1'b0, d, 0, dummy);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] res);
    cpu_acc(a, 1'b1, 8'h00, 0, res);
  endtask

  typedef struct packed { logic [2:0] a; logic [7:0] wd; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [7] = '{
    '{3'b000, 8'hA5, 8'hA5}, '{3'b001, 8'h5B, 8'h5B}, '{3'b101, 8'hC3, 8'hC3},
    '{3'b110, 8'h01, 8'h00}, '{3'b010, 8'hFF, 8'h00}, '{3'b011, 8'hFF, 8'h00},
    '{3'b111, 8'hFF, 8'h00}
  };

  initial begin
    int g0, a0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 go", {7'd0, eng_go}, 8'h00);
    rd(3'b100, q); chk("R1 status", q, 8'h02);
    rd(3'b000, q); chk("R1 data", q, 8'h00);
    rd(3'b101, q); chk("R1 count", q, 8'h00);
    chk("R3 idle rdata", rdata, 8'h00);

    // R3 / R2 write-readback table, reserved addresses ignored
    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].wd);
      rd(VECS[i].a, q);
      chk("R3 R2 readback", q, VECS[i].exp);
    end
    // R4 slave address fields
    chk("R4 slave addr", {1'b0, eng_slave_addr}, 8'h2D);
    chk("R4 rw", {7'd0, eng_rw}, 8'h01);

    // R2 commit on the third edge
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = 3'b101; wdata = 8'h77;
    @(posedge clk); @(negedge clk); chk("R2 edge1", eng_byte_cnt, 8'hC3);
    @(posedge clk); @(negedge clk); chk("R2 edge2", eng_byte_cnt, 8'hC3);
    @(posedge clk); @(negedge clk); chk("R2 edge3", eng_byte_cnt, 8'h77);
    @(posedge clk); @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;

    // R5 go pulse, speed mode, abort pulse
    g0 = go_seen; a0 = abort_seen;
    wr(3'b100, 8'h88);
    chk("R5 go count", 8'(go_seen - g0), 8'h01);
    chk("R5 abort idle", 8'(abort_seen - a0), 8'h00);
    chk("R5 fast", {7'd0, eng_fast}, 8'h01);
    wr(3'b100, 8'h40);
    chk("R5 abort count", 8'(abort_seen - a0), 8'h01);
    chk("R5 go once", 8'(go_seen - g0), 8'h01);
    chk("R5 fast cleared", {7'd0, eng_fast}, 8'h00);

    // R6 status layout
    busy = 1; aack = 1; done = 1;
    rd(3'b100, q); chk("R6 status A", q, 8'hA8);
    busy = 0; aack = 0; done = 0; err = 1; lost = 1;
    rd(3'b100, q); chk("R6 status B", q, 8'h50);
    err = 0; lost = 0;

    // R7 transmit-empty handshake and same-cycle priority
    @(negedge clk); tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
    rd(3'b100, q); chk("R7 set by take", q, 8'h02);
    cpu_acc(3'b000, 1'b0, 8'h11, 1, q);
    rd(3'b100, q); chk("R7 clear wins", q, 8'h00);

    // R9 / R10 transmit interrupt
    wr(3'b100, 8'h02);
    chk("R9 no irq yet", {7'd0, irq_n}, 8'h01);
    @(negedge clk); tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
    @(negedge clk); chk("R9 tx irq", {7'd0, irq_n}, 8'h00);
    wr(3'b110, 8'h00);
    chk("R10 bit0 clear no effect", {7'd0, irq_n}, 8'h00);
    wr(3'b110, 8'h01);
    chk("R10 ack", {7'd0, irq_n}, 8'h01);
    wr(3'b000, 8'h22);
    wr(3'b100, 8'h01);
    chk("R9 quiet", {7'd0, irq_n}, 8'h01);

    // R8 / R9 receive path with timing
    @(negedge clk); rx_load = 1'b1; rx_byte = 8'h3C;
    @(posedge clk); @(negedge clk); rx_load = 1'b0;
    chk("R9 not before", {7'd0, irq_n}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R9 one later", {7'd0, irq_n}, 8'h00);
    rd(3'b100, q); chk("R8 full", q, 8'h01);
    rd(3'b000, q); chk("R8 data", q, 8'h3C);
    rd(3'b100, q); chk("R8 cleared", q, 8'h00);
    wr(3'b110, 8'h01);

    // R8 same-cycle load and read
    @(negedge clk); rx_load = 1'b1; rx_byte = 8'h55; @(negedge clk); rx_load = 1'b0;
    rx_byte = 8'h99;
    cpu_acc(3'b000, 1'b1, 8'h00, 2, q); chk("R8 old byte", q, 8'h55);
    rd(3'b100, q); chk("R8 set wins", q, 8'h01);
    rd(3'b000, q); chk("R8 new byte", q, 8'h99);
    rd(3'b100, q); chk("R8 final", q, 8'h00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule